// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt lines into two banks of 32 and drives one interrupt request toward a single processor. Each line is either edge-type or level-type, as set by a fixed per-bank bitmap. An edge-type line latches a pending event on every rising transition. That event stays latched until software acknowledges it, even after the line has dropped. A level-type line latches nothing. It requests service exactly while its input is high, and acknowledge writes do not affect it.

Software reaches each bank through a small 32-bit register window addressed by 12 bits. A write to the mask register selects which lines may raise the request. A read returns the pending events or the current line levels. An acknowledge write clears the selected pending events. The request output is the OR over both banks of the enabled pending and level-active lines. Read data is returned in the same cycle as the address.

Top module: `irq_ctrl_dual`

## Requirements
- R1: After a synchronous reset, the pending, mask and level registers of both banks read zero and `irq_out` is 0. The level-type bitmap is all zero for the bank at 0x10. For the bank at 0x20 it is 0x1FF00000, so lines 20 to 28 are level-type.
- R2: Input lines 0..31 belong to the bank at 0x20 and lines 32..63 to the bank at 0x10. The bit position inside a bank is the line number modulo 32.
- R3: Offset 0xC of a bank reads the line levels as sampled on the previous clock edge.
- R4: A 0-to-1 transition on an edge-type line sets its bit in the pending register (offset 0x0) on that clock edge. A 1-to-0 transition leaves the pending bit unchanged.
- R5: A level-type line never sets its pending bit.
- R6: A write to offset 0x4 loads the bank's mask, and a read of offset 0x4 returns it.
- R7: A write to offset 0x8 clears each pending bit whose written-data bit is 1, except on level-type lines.
- R8: `irq_out` is 1 exactly when, in either bank, the AND of the mask with (pending OR (levels AND level-type bitmap)) is nonzero. It follows a register update in the same cycle that update becomes visible.
- R9: If a rising edge and an acknowledge of the same pending bit fall on the same clock edge, the bit ends up set.
- R10: The bank index is ((addr − 0x10) mod 4096) >> 4, and the offset is addr[3:0]. An index of 2 or more, offset 0x8, or any offset other than 0x0, 0x4, 0x8 and 0xC reads as zero and ignores writes. Read data is zero unless `bus_valid` is 1 and `bus_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 64 | Interrupt input lines, bit n is line n |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two operations can hit the same pending bit on one clock edge: a rising edge on a line and an acknowledge write that clears that line. The bench provokes this on purpose by raising a line in the same cycle as an acknowledge of its bit. It expects the bit to stay set. A long random phase then runs line toggles together with mask writes, acknowledge writes and reads at legal and illegal addresses. A behavioural per-line model judges every cycle, comparing read data and the request output on each clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register offsets inside one bank window
  localparam int OFS_PEND  = 'h0;
  localparam int OFS_MASK  = 'h4;
  localparam int OFS_CLEAR = 'h8;
  localparam int OFS_LEVEL = 'hC;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int AW = 12,
  parameter int NB = 2,
  parameter int SL = 4,
  parameter logic [AW-1:0] BASE = 'h10
) (
  input  logic          valid,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic [NB-1:0] sel,
  output logic          hit,
  output logic [SL-1:0] ofs,
  output logic [NB-1:0] mask_we,
  output logic [NB-1:0] clr_we
);
  import irqc_pkg::*;

  logic [AW-1:0] rel;
  logic [AW-1:0] idx;

  always_comb begin
    rel = addr - BASE;
    idx = rel >> SL;
    hit = (idx < AW'(NB));
    ofs = addr[SL-1:0];
  end

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign sel[b]     = hit && (idx == AW'(b));
    assign mask_we[b] = valid && we && sel[b] && (ofs == SL'(OFS_MASK));
    assign clr_we[b]  = valid && we && sel[b] && (ofs == SL'(OFS_CLEAR));
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] LVL_CFG = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_in,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] levels,
  output logic         req
);
  logic [W-1:0] rise_edge;
  logic [W-1:0] clr_bits;
  logic [W-1:0] pend_nxt;

  always_comb begin
    // levels holds last sample, so it doubles as edge history
    rise_edge = line_in & ~levels & ~LVL_CFG;
    clr_bits  = clr_we ? (wdata & ~LVL_CFG) : '0;
    pend_nxt  = (pend & ~clr_bits) | rise_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      mask   <= '0;
      levels <= '0;
    end else begin
      levels <= line_in;
      pend   <= pend_nxt;
      if (mask_we) mask <= wdata;
    end
  end

  assign req = |((pend | (levels & LVL_CFG)) & mask);

  AST_LEVELS_TRACK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (levels == $past(line_in))); // R3
  AST_RISE_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend & $past(rise_edge)) == $past(rise_edge))); // R9
  AST_LEVEL_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (pend & LVL_CFG) == '0); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr_we)) |->
      ((pend & $past(wdata & ~LVL_CFG & ~rise_edge)) == '0)); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_we)) |-> (mask == $past(wdata))); // R6
endmodule

// File: rtl/irq_ctrl_dual.sv
module irq_ctrl_dual #(
  parameter int W  = 32,
  parameter int NB = 2,
  parameter int AW = 12,
  parameter int SL = 4,
  parameter logic [AW-1:0] BASE = 'h10,
  parameter logic [NB*W-1:0] LVL_MAP = {32'h1FF00000, 32'h00000000}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NB*W-1:0] irq_lines,
  input  logic            bus_valid,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic            irq_out
);
  import irqc_pkg::*;

  logic [NB-1:0] sel;
  logic          hit;
  logic [SL-1:0] ofs;
  logic [NB-1:0] mask_we;
  logic [NB-1:0] clr_we;
  logic [NB-1:0] req;
  logic [W-1:0]  pend_a [NB];
  logic [W-1:0]  mask_a [NB];
  logic [W-1:0]  lvl_a  [NB];

  irqc_decode #(.AW(AW), .NB(NB), .SL(SL), .BASE(BASE)) u_dec (
    .valid(bus_valid), .we(bus_we), .addr(bus_addr),
    .sel(sel), .hit(hit), .ofs(ofs), .mask_we(mask_we), .clr_we(clr_we)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    // highest line group feeds bank 0
    localparam int GRP = NB - 1 - b;
    irqc_bank #(.W(W), .LVL_CFG(LVL_MAP[b*W +: W])) u_bank (
      .clk(clk), .rst(rst),
      .line_in(irq_lines[GRP*W +: W]),
      .mask_we(mask_we[b]), .clr_we(clr_we[b]), .wdata(bus_wdata),
      .pend(pend_a[b]), .mask(mask_a[b]), .levels(lvl_a[b]), .req(req[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_valid && !bus_we && sel[b]) begin
        if (ofs == SL'(OFS_PEND))  bus_rdata = pend_a[b];
        if (ofs == SL'(OFS_MASK))  bus_rdata = mask_a[b];
        if (ofs == SL'(OFS_LEVEL)) bus_rdata = lvl_a[b];
      end
    end
  end

  assign irq_out = |req;

  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !hit) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/tb_irq_ctrl_dual.sv
`timescale 1ns/1ps
module tb_irq_ctrl_dual;
  logic        clk = 0;
  logic        rst = 1;
  logic [63:0] lines = '0;
  logic        d_v = 0, d_we = 0;
  logic [11:0] d_a = '0;
  logic [31:0] d_wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_pend [2];
  logic [31:0] m_mask [2];
  logic [31:0] m_lvl  [2];
  logic [31:0] lvl_type [2];

  irq_ctrl_dual dut (
    .clk(clk), .rst(rst), .irq_lines(lines), .bus_valid(d_v), .bus_we(d_we),
    .bus_addr(d_a), .bus_wdata(d_wd), .bus_rdata(rdata), .irq_out(irq)
  );

  always #5 clk = ~clk;

  function automatic int bank_of(input logic [11:0] a);
    int rel;
    rel = (int'(a) - 16) & 'hFFF;
    return rel >> 4;
  endfunction

  task automatic model_step();
    int bk, bt, idx, ofs;
    bit old_lv, now_lv, is_lvl;
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        m_pend[b] = 0; m_mask[b] = 0; m_lvl[b] = 0;
      end
      return;
    end
    idx = bank_of(d_a);
    ofs = int'(d_a) & 'hF;
    for (int n = 0; n < 64; n++) begin
      bk = (n < 32) ? 1 : 0;
      bt = n % 32;
      old_lv = m_lvl[bk][bt];
      now_lv = lines[n];
      is_lvl = lvl_type[bk][bt];
      if (d_v && d_we && idx == bk && ofs == 8 && d_wd[bt] && !is_lvl)
        m_pend[bk][bt] = 1'b0;
      if (now_lv && !old_lv && !is_lvl)
        m_pend[bk][bt] = 1'b1;
      m_lvl[bk][bt] = now_lv;
    end
    if (d_v && d_we && idx < 2 && ofs == 4) m_mask[idx] = d_wd;
  endtask

  function automatic logic [31:0] exp_rd();
    int idx, ofs;
    if (!(d_v && !d_we)) return 0;
    idx = bank_of(d_a);
    ofs = int'(d_a) & 'hF;
    if (idx >= 2) return 0;
    case (ofs)
      0:  return m_pend[idx];
      4:  return m_mask[idx];
      12: return m_lvl[idx];
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic r = 0;
    for (int b = 0; b < 2; b++)
      if (((m_pend[b] | (m_lvl[b] & lvl_type[b])) & m_mask[b]) != 0) r = 1;
    return r;
  endfunction

  task automatic compare();
    logic [31:0] er;
    logic ei;
    er = exp_rd();
    ei = exp_irq();
    checks++;
    if (rdata !== er) begin
      errors++;
      $display("FAIL %s rdata addr %h got %h exp %h", cur_req, d_a, rdata, er);
    end
    checks++;
    if (irq !== ei) begin
      errors++;
      $display("FAIL %s irq_out got %b exp %b", cur_req, irq, ei);
    end
  endtask

  task automatic step(input logic v, input logic we, input logic [11:0] a,
                      input logic [31:0] wd);
    d_v = v; d_we = we; d_a = a; d_wd = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input logic [11:0] a);
    step(1, 0, a, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd);
    step(1, 1, a, wd);
  endtask

  initial begin
    lvl_type[0] = 32'h00000000;
    lvl_type[1] = 32'h1FF00000;
    for (int b = 0; b < 2; b++) begin
      m_pend[b] = 0; m_mask[b] = 0; m_lvl[b] = 0;
    end
    rst = 1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    rst = 0;
    cur_req = "R1";
    rd(12'h010); rd(12'h014); rd(12'h01C);
    rd(12'h020); rd(12'h024); rd(12'h02C);

    cur_req = "R6";
    wr(12'h014, 32'hA5A5_0F0F); rd(12'h014);
    wr(12'h024, 32'h0000_0000); rd(12'h024);
    wr(12'h014, 32'h0000_0000);

    cur_req = "R2";
    lines[5] = 1; rd(12'h02C);
    lines[40] = 1; rd(12'h01C);
    cur_req = "R3";
    lines[63] = 1; rd(12'h01C); rd(12'h01C);

    cur_req = "R4";
    rd(12'h020); rd(12'h010);
    lines[5] = 0; rd(12'h020); rd(12'h02C);

    cur_req = "R5";
    lines[22] = 1; rd(12'h020); rd(12'h02C);
    cur_req = "R8";
    wr(12'h024, 32'h0040_0000); rd(12'h024);
    lines[22] = 0; rd(12'h020);
    lines[22] = 1; rd(12'h020);

    cur_req = "R7";
    wr(12'h028, 32'hFFFF_FFFF); rd(12'h020);
    wr(12'h018, 32'h0000_0100); rd(12'h010);
    wr(12'h018, 32'hFFFF_FFFF); rd(12'h010);

    cur_req = "R8";
    wr(12'h024, 32'h0000_0000); rd(12'h020);
    lines[22] = 0;
    lines[9] = 1; wr(12'h024, 32'h0000_0200); rd(12'h020);
    wr(12'h028, 32'h0000_0200); rd(12'h020);

    cur_req = "R9";
    lines[7] = 1; wr(12'h028, 32'h0000_0080); rd(12'h020);
    lines[7] = 0; wr(12'h028, 32'h0000_0080); rd(12'h020);

    cur_req = "R10";
    wr(12'h034, 32'hFFFF_FFFF); rd(12'h034); rd(12'h014); rd(12'h024);
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004); rd(12'h014);
    wr(12'h015, 32'hFFFF_FFFF); rd(12'h015); rd(12'h014);
    lines[33] = 1; rd(12'h010);
    wr(12'h01C, 32'hFFFF_FFFF); rd(12'h010); rd(12'h018); rd(12'h011);
    step(0, 0, 12'h010, 0);
    step(1, 1, 12'h014, 32'h0);

    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] flip;
      logic [11:0] a;
      int sel;
      flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      lines = lines ^ flip;
      sel = $urandom % 12;
      case (sel)
        0: a = 12'h010; 1: a = 12'h014; 2: a = 12'h018; 3: a = 12'h01C;
        4: a = 12'h020; 5: a = 12'h024; 6: a = 12'h028; 7: a = 12'h02C;
        8: a = 12'h000; 9: a = 12'h030; 10: a = 12'hFF4; default: a = 12'h012;
      endcase
      step(($urandom % 4) != 0, ($urandom % 2) == 0, a, $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule